// File: doc/BRIEF.md
# Splittable Event Counter Bank

This block counts hardware events for performance monitoring. It holds four physical 32-bit counters. Any physical counter can be switched, at run time, into a pair of independent 16-bit counters, so software sees up to eight logical counters. Each logical counter has its own control word. The control word picks one line of a 64-bit event bus, can invert that line, chooses between counting rising edges and counting cycles in which the line is high, and enables the counter.

A global control word gates the whole bank. It holds a master enable, a freeze, saturation at the maximum value in place of wrap-around, the split selects, and a filter on the processor's current privilege state. Overflows set sticky flags in a status word. Reading the status word clears those flags. A mask register selects which flags drive the interrupt line.

Software reaches every register through a single-cycle read/write port. Read data is combinational on the address. Writes and the clear-on-read take effect at the next rising clock edge.

Top module: `evtctr_bank`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every register reads as zero and irq is low.
- R2: A logical counter increments only in a cycle where all of the following hold: global bit 31 (master) is set, global bit 20 (freeze) is clear, the counter's enable (control bit 22) is set, and the privilege filter passes. The filter is global bits 19:18. priv_state encodes 0 = supervisor, 1 = hypervisor, 2 = user. The filter passes when it equals 3, or when it equals priv_state.
- R3: Logical counter n observes event_bus[sel], where sel is its control bits 31:26. When control bit 24 (polarity) is set, that line is inverted before use.
- R4: When control bit 23 (cycle mode) is set, the counter counts every qualifying cycle in which the observed line is 1. When bit 23 is clear, it counts only cycles where the observed line is 1 and was 0 in the previous cycle. The previous value is 0 after reset.
- R5: Global bit (24 - p) puts physical counter p (0..3) in split mode. In split mode, bits 15:0 form logical counter p and bits 31:16 form logical counter p+4. Each half has its own control word and rolls over at 16 bits. When bit (24 - p) is clear, logical counter p drives all 32 bits and logical counter p+4 has no effect.
- R6: When a counter at its all-ones value increments and global bit 30 is clear, it wraps to zero. Status bit (31 - n) is then set for logical counter n.
- R7: When global bit 30 (stop-at-max) is set, a counter at all ones that would increment holds its value. Its status bit is still set.
- R8: A read strobe at address 13 returns the status flags in that cycle and clears them at the clock edge. A flag raised in that same cycle survives the clear.
- R9: irq is high while any status flag is set whose mask bit, at the same bit position in the mask register (address 14), is also set.
- R10: A write to a counter address replaces the value at the clock edge. The write overrides any increment in that cycle and sets no flag.
- R11: Address map: 0..3 are physical counters, 4..11 are the control words of logical counters 0..7, 12 is global control, 13 is status, and 14 is the interrupt mask. Control words keep bits 31:22. Global control keeps bits 31, 30, 24:21, 20 and 19:18. All other bits, and address 15, read as zero. Writes to address 13 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe. It only matters for the status clear. |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on reg_addr |
| event_bus | input | 64 | Event lines |
| priv_state | input | 2 | Current privilege state |
| irq | output | 1 | Masked overflow interrupt |

## Verification
A wrong internal state shows up at the ports within one clock. Counter values and flags are visible through reg_rdata as soon as they are registered. The bench keeps an arithmetic model and compares one counter or the status word on every cycle, and compares irq on every cycle. A bad edge-detect history shows up as a count that is off by one on the next rising edge of the selected line. A wrong split or saturation choice shows up as a wrong value right after the boundary is crossed.

// File: rtl/evtctr_pkg.sv
// Shared types and register addresses of the event counter bank.
// Assumes a 32-bit register port and a fixed control-word layout.
package evtctr_pkg;

    typedef struct packed {
        logic [5:0] sel;    // event line index
        logic       inctl;  // stored input-control bit
        logic       pol;    // invert the selected line
        logic       cyc;    // level (cycle) counting
        logic       en;     // counter enable
    } ctl_t;

    localparam logic [3:0] ADR_CTL0 = 4'd4;
    localparam logic [3:0] ADR_GLB  = 4'd12;
    localparam logic [3:0] ADR_STAT = 4'd13;
    localparam logic [3:0] ADR_MASK = 4'd14;

endpackage

// File: rtl/evtctr_qual.sv
// Event qualifier for one logical counter: selects a line, applies the
// polarity, and produces a per-cycle hit in level or rising-edge mode.
// Assumes ctl.sel indexes within EVW lines.
module evtctr_qual
    import evtctr_pkg::*;
#(
    parameter int EVW = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [EVW-1:0] ev_bus,
    input  ctl_t           ctl,
    output logic           hit
);
    localparam int SELW = $clog2(EVW);

    logic qual;
    logic prev_q;

    // Select the event line and apply the polarity.
    always_comb begin
        qual = ev_bus[ctl.sel[SELW-1:0]] ^ ctl.pol;
        hit  = ctl.cyc ? qual : (qual & ~prev_q);
    end

    // Remember last cycle's observed level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= qual;
    end

    // A rising edge cannot be reported twice in a row in edge mode.
    AST_EDGE_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.cyc && hit) |=> (ctl.cyc || !hit)); // R4

endmodule

// File: rtl/evtctr_phys.sv
// One physical counter of width CW. It works either as one full-width
// counter driven by inc_lo, or as two half-width counters. Each half
// wraps or saturates on its own. Assumes CW is even.
module evtctr_phys #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          split,
    input  logic          inc_lo,
    input  logic          inc_hi,
    input  logic          stop_max,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] count,
    output logic          ovf_lo,
    output logic          ovf_hi
);
    localparam int HW = CW / 2;

    logic [CW-1:0] nxt;

    // Compute the next count and the overflow events for this cycle.
    always_comb begin
        nxt    = count;
        ovf_lo = 1'b0;
        ovf_hi = 1'b0;
        if (wr_en) begin
            nxt = wr_data;
        end else if (split) begin
            if (inc_lo) begin
                if (&count[HW-1:0]) begin
                    ovf_lo = 1'b1;
                    if (!stop_max) nxt[HW-1:0] = '0;
                end else begin
                    nxt[HW-1:0] = count[HW-1:0] + 1'b1;
                end
            end
            if (inc_hi) begin
                if (&count[CW-1:HW]) begin
                    ovf_hi = 1'b1;
                    if (!stop_max) nxt[CW-1:HW] = '0;
                end else begin
                    nxt[CW-1:HW] = count[CW-1:HW] + 1'b1;
                end
            end
        end else if (inc_lo) begin
            if (&count) begin
                ovf_lo = 1'b1;
                if (!stop_max) nxt = '0;
            end else begin
                nxt = count + 1'b1;
            end
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= nxt;
    end

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (count == $past(wr_data))); // R10
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_max && !split && (&count) && !wr_en) |=> (&count)); // R7
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_max && !split && (&count) && inc_lo && !wr_en) |=> (count == '0)); // R6

endmodule

// File: rtl/evtctr_bank.sv
// Splittable event counter bank: global and per-counter registers,
// status flags with clear-on-read, masked interrupt, and a register port.
// Assumes a 32-bit register port and NP <= 4 (split bits sit at 24-p).
module evtctr_bank
    import evtctr_pkg::*;
#(
    parameter int NP  = 4,
    parameter int CW  = 32,
    parameter int EVW = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic           reg_rd,
    input  logic [3:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    input  logic [EVW-1:0] event_bus,
    input  logic [1:0]     priv_state,
    output logic           irq
);
    localparam int NL = 2 * NP;

    logic               master_q, stop_q, freeze_q;
    logic [1:0]         filt_q;
    logic [NP-1:0]      split_q;
    ctl_t               ctl_q [NL];
    logic [NL-1:0]      mask_q, flag_q;
    logic [NL-1:0]      hit, inc, ovf_vec;
    logic [NP-1:0]      ovf_lo, ovf_hi;
    logic [NP-1:0][CW-1:0] cnt;
    logic               gate, rd_stat;

    // Global gate: master on, not frozen, privilege filter passes.
    always_comb begin
        gate    = master_q && !freeze_q && ((filt_q == 2'd3) || (priv_state == filt_q));
        rd_stat = reg_rd && (reg_addr == ADR_STAT);
    end

    // Global control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_q <= 1'b0;
            stop_q   <= 1'b0;
            freeze_q <= 1'b0;
            filt_q   <= 2'd0;
            split_q  <= '0;
        end else if (reg_wr && reg_addr == ADR_GLB) begin
            master_q <= reg_wdata[31];
            stop_q   <= reg_wdata[30];
            freeze_q <= reg_wdata[20];
            filt_q   <= reg_wdata[19:18];
            for (int p = 0; p < NP; p++) split_q[p] <= reg_wdata[24-p];
        end
    end

    // Per-counter control words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NL; n++) ctl_q[n] <= '0;
        end else if (reg_wr && reg_addr >= ADR_CTL0 && reg_addr < ADR_CTL0 + 4'(NL)) begin
            ctl_q[reg_addr - ADR_CTL0] <= reg_wdata[31:22];
        end
    end

    // Interrupt mask, stored per logical counter from bit 31-n.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (reg_wr && reg_addr == ADR_MASK) begin
            for (int n = 0; n < NL; n++) mask_q[n] <= reg_wdata[31-n];
        end
    end

    // Sticky overflow flags; a status read clears them, new overflows win.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (rd_stat ? '0 : flag_q) | ovf_vec;
    end

    assign irq = |(flag_q & mask_q);

    genvar g;
    generate
        for (g = 0; g < NL; g++) begin : g_lc
            evtctr_qual #(.EVW(EVW)) qual_i (
                .clk(clk), .rst_n(rst_n), .ev_bus(event_bus),
                .ctl(ctl_q[g]), .hit(hit[g])
            );
            assign inc[g] = gate && ctl_q[g].en && hit[g];
        end
        for (g = 0; g < NP; g++) begin : g_pc
            evtctr_phys #(.CW(CW)) phys_i (
                .clk(clk), .rst_n(rst_n), .split(split_q[g]),
                .inc_lo(inc[g]), .inc_hi(inc[g+NP]), .stop_max(stop_q),
                .wr_en(reg_wr && reg_addr == 4'(g)),
                .wr_data(reg_wdata[CW-1:0]), .count(cnt[g]),
                .ovf_lo(ovf_lo[g]), .ovf_hi(ovf_hi[g])
            );
            assign ovf_vec[g]    = ovf_lo[g];
            assign ovf_vec[g+NP] = ovf_hi[g];
        end
    endgenerate

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr < 4'(NP)) begin
            reg_rdata[CW-1:0] = cnt[reg_addr[1:0]];
        end else if (reg_addr >= ADR_CTL0 && reg_addr < ADR_CTL0 + 4'(NL)) begin
            reg_rdata[31:22] = ctl_q[reg_addr - ADR_CTL0];
        end else if (reg_addr == ADR_GLB) begin
            reg_rdata[31]    = master_q;
            reg_rdata[30]    = stop_q;
            reg_rdata[20]    = freeze_q;
            reg_rdata[19:18] = filt_q;
            for (int p = 0; p < NP; p++) reg_rdata[24-p] = split_q[p];
        end else if (reg_addr == ADR_STAT) begin
            for (int n = 0; n < NL; n++) reg_rdata[31-n] = flag_q[n];
        end else if (reg_addr == ADR_MASK) begin
            for (int n = 0; n < NL; n++) reg_rdata[31-n] = mask_q[n];
        end
    end

    AST_STAT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (flag_q == $past(ovf_vec))); // R8
    AST_HALT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_q && !reg_wr) |=> $stable(cnt)); // R2
    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_q && !reg_wr) |=> $stable(cnt)); // R2

endmodule

// File: tb/evtctr_bank_tb_top.sv
// Self-checking bench: a cycle-level arithmetic model of the requirements,
// compared against reg_rdata and irq on every cycle.
module evtctr_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] event_bus = '0;
    logic [1:0]  priv_state = '0;
    logic        irq;

    always #10 clk = ~clk;

    evtctr_bank dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .event_bus(event_bus), .priv_state(priv_state), .irq(irq)
    );

    int checks = 0, fails = 0;
    string cur_req = "R1";

    // model state
    logic        m_en, m_stop, m_frz;
    logic [1:0]  m_filt;
    logic [3:0]  m_split;
    logic [31:0] m_ctl [8];
    logic [7:0]  m_mask, m_flags, m_prev;
    logic [31:0] m_cnt [4];
    logic [63:0] ev_cur = '0;
    logic [1:0]  pv_cur = '0;
    logic        use_lfsr = 1'b0;
    int          mon = 0;

    function automatic logic [31:0] rev8(input logic [7:0] v);
        logic [31:0] w = '0;
        for (int n = 0; n < 8; n++) w[31-n] = v[n];
        return w;
    endfunction

    function automatic logic [31:0] model_read(input logic [3:0] a);
        logic [31:0] w = '0;
        if (a < 4) w = m_cnt[a[1:0]];
        else if (a < 12) w = m_ctl[a-4];
        else if (a == 12) begin
            w[31] = m_en; w[30] = m_stop; w[20] = m_frz; w[19:18] = m_filt;
            for (int p = 0; p < 4; p++) w[24-p] = m_split[p];
        end
        else if (a == 13) w = rev8(m_flags);
        else if (a == 14) w = rev8(m_mask);
        return w;
    endfunction

    function automatic logic [31:0] gword(input logic en, stop, frz,
                                          input logic [3:0] spl, input logic [1:0] f);
        logic [31:0] w = '0;
        w[31] = en; w[30] = stop; w[20] = frz; w[19:18] = f;
        for (int p = 0; p < 4; p++) w[24-p] = spl[p];
        return w;
    endfunction

    function automatic logic [31:0] cword(input logic [5:0] sel, input logic pol, cy, en);
        return {sel, 1'b0, pol, cy, en, 22'd0};
    endfunction

    task automatic model_reset();
        m_en = 0; m_stop = 0; m_frz = 0; m_filt = 0; m_split = 0;
        m_mask = 0; m_flags = 0; m_prev = 0;
        for (int i = 0; i < 8; i++) m_ctl[i] = 0;
        for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    endtask

    // Advance the model by one clock edge.
    task automatic model_edge(input logic wr, rd, input logic [3:0] a,
                              input logic [31:0] d, input logic [63:0] ev,
                              input logic [1:0] pv);
        logic [7:0] inc, newf;
        logic gate, q, h;
        logic [15:0] hv;
        gate = m_en && !m_frz && (m_filt == 3 || pv == m_filt);
        newf = 0;
        for (int n = 0; n < 8; n++) begin
            q = ev[m_ctl[n][31:26]] ^ m_ctl[n][24];
            h = m_ctl[n][23] ? q : (q && !m_prev[n]);
            m_prev[n] = q;
            inc[n] = gate && m_ctl[n][22] && h;
        end
        for (int p = 0; p < 4; p++) begin
            if (wr && a == 4'(p)) m_cnt[p] = d;
            else if (m_split[p]) begin
                for (int half = 0; half < 2; half++) begin
                    if (inc[p + 4*half]) begin
                        hv = m_cnt[p][16*half +: 16];
                        if (hv == 16'hFFFF) begin
                            newf[p + 4*half] = 1;
                            if (!m_stop) hv = 0;
                        end else hv = hv + 1;
                        m_cnt[p][16*half +: 16] = hv;
                    end
                end
            end else if (inc[p]) begin
                if (m_cnt[p] == 32'hFFFF_FFFF) begin
                    newf[p] = 1;
                    if (!m_stop) m_cnt[p] = 0;
                end else m_cnt[p] = m_cnt[p] + 1;
            end
        end
        m_flags = ((rd && a == 13) ? 8'h00 : m_flags) | newf;
        if (wr) begin
            if (a >= 4 && a < 12) m_ctl[a-4] = d & 32'hFFC0_0000;
            else if (a == 12) begin
                m_en = d[31]; m_stop = d[30]; m_frz = d[20]; m_filt = d[19:18];
                for (int p = 0; p < 4; p++) m_split[p] = d[24-p];
            end else if (a == 14) for (int n = 0; n < 8; n++) m_mask[n] = d[31-n];
        end
    endtask

    // One bus cycle: drive, check outputs before the edge, then step the model.
    task automatic cyc(input logic wr, rd, input logic [3:0] a, input logic [31:0] d);
        logic [31:0] exp;
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
        event_bus = ev_cur; priv_state = pv_cur;
        #2;
        exp = model_read(a);
        checks++;
        if (reg_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr %0d act %h exp %h", cur_req, a, reg_rdata, exp);
        end
        checks++;
        if (irq !== |(m_flags & m_mask)) begin
            fails++;
            $display("FAIL R9 irq act %b exp %b", irq, |(m_flags & m_mask));
        end
        @(posedge clk);
        model_edge(wr, rd, a, d, ev_cur, pv_cur);
        if (use_lfsr) ev_cur = {ev_cur[62:0], ev_cur[63] ^ ev_cur[62] ^ ev_cur[60] ^ ev_cur[59]};
        @(negedge clk);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            cyc(0, 0, (mon == 4) ? 4'd13 : 4'(mon), 32'd0);
            mon = (mon + 1) % 5;
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        cyc(1, 0, a, d);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every address reads zero after reset, irq low
        cur_req = "R1";
        for (int a = 0; a < 16; a++) cyc(0, 0, 4'(a), 0);

        // R11: register field retention and address map (freeze keeps counts still)
        cur_req = "R11";
        wr_reg(12, 32'hFFFF_FFFF);
        for (int n = 0; n < 8; n++) wr_reg(4'(4+n), 32'hFFFF_FFFF);
        wr_reg(14, 32'hFFFF_FFFF);
        wr_reg(13, 32'hFFFF_FFFF);
        for (int a = 0; a < 16; a++) cyc(0, 0, 4'(a), 0);
        wr_reg(14, 0);

        // R3, R4, R5: sweep selects, polarity, mode and split over all counters
        use_lfsr = 1'b1;
        ev_cur = 64'h9E37_79B9_7F4A_7C15;
        for (int n = 0; n < 8; n++) begin
            for (int m = 0; m < 4; m++) begin
                cur_req = (n >= 4) ? "R5" : (m[1] ? "R4" : "R3");
                wr_reg(12, gword(1, 0, 0, (n >= 4) ? 4'hF : 4'h5, 2'd3));
                wr_reg(4'(4+n), cword(6'((n*7 + m*13) % 64), m[0], m[1], 1'b1));
                wr_reg(4'(n % 4), 32'h0000_FFF0 + 32'(n));
                idle(12);
            end
        end
        use_lfsr = 1'b0;

        // R2: privilege filter, master and freeze over all combinations
        ev_cur = '0;
        for (int n = 0; n < 8; n++) wr_reg(4'(4+n), cword(6'd0, 1'b1, 1'b1, 1'b1));
        cur_req = "R2";
        for (int f = 0; f < 4; f++)
            for (int pv = 0; pv < 4; pv++)
                for (int ef = 0; ef < 4; ef++) begin
                    pv_cur = 2'(pv);
                    wr_reg(12, gword(ef[0], 0, ef[1], 4'h0, 2'(f)));
                    idle(4);
                end
        pv_cur = 0;

        // R6, R7, R8, R9: wrap or saturate at the boundary, flags, clear, irq
        wr_reg(14, 32'hFFFF_FFFF);
        for (int s = 0; s < 2; s++) begin
            cur_req = s ? "R7" : "R6";
            wr_reg(12, gword(0, s[0], 0, 4'b0011, 2'd3));
            wr_reg(0, 32'hFFFE_FFFD);
            wr_reg(1, 32'h0001_FFFF);
            wr_reg(2, 32'hFFFF_FFFE);
            wr_reg(3, 32'h7FFF_FFFF);
            wr_reg(12, gword(1, s[0], 0, 4'b0011, 2'd3));
            idle(5);
            cur_req = "R8";
            cyc(0, 1, 13, 0);
            cyc(0, 0, 13, 0);
            wr_reg(12, gword(0, s[0], 0, 4'b0011, 2'd3));
            cyc(0, 1, 13, 0);
            cyc(0, 0, 13, 0);
        end
        cur_req = "R9";
        wr_reg(14, 32'h4000_0000);           // only logical counter 1
        wr_reg(0, 32'hFFFF_FFFF);
        wr_reg(12, gword(1, 0, 0, 4'b0000, 2'd3));
        idle(2);                              // counter 0 wraps, irq stays low
        wr_reg(1, 32'hFFFF_FFFF);
        idle(3);                              // counter 1 wraps, irq rises
        cyc(0, 1, 13, 0);
        idle(2);

        // R10: writes during active counting win over the increment
        cur_req = "R10";
        for (int p = 0; p < 4; p++) begin
            wr_reg(4'(p), 32'hFFFF_FFFF);
            wr_reg(4'(p), 32'h1234_0000 + 32'(p));
            idle(2);
        end
        wr_reg(12, gword(1, 1, 0, 4'hF, 2'd3));
        for (int p = 0; p < 4; p++) begin
            wr_reg(4'(p), 32'hFFFF_FFFF);
            wr_reg(4'(p), 32'h0000_0005);
            idle(2);
        end
        cyc(0, 1, 13, 0);
        idle(2);

        summary();
    end
endmodule